// File: doc/BRIEF.md
# Lockable SMRAM Control Register Pair

This block holds the two 8-bit configuration registers a host bridge uses to steer system-management RAM: a main control register and an extended control register. Configuration software writes and reads them one byte at a time through a simple address/strobe port. Each register has its own write mask. A write changes only the bits whose mask bit is set.

The main register carries a one-way lock bit. Any update that leaves the lock bit at 1 forces the open bit to 0 in the same update. The same update removes write permission from the security-relevant fields of both registers. Only a hardware reset gives that permission back, so firmware must set the lock again after each reset, including a wake from a sleep state.

The stored fields are decoded into registered control outputs for the downstream address-decode logic. That logic does the memory steering itself.

Top module: `smram_lock_regs`

## Requirements
- R1: After reset, the main register reads CTL_DEFAULT (0x02), the extended register reads EXT_DEFAULT (0x00), and both write masks are all ones, so every bit of both registers is writable.
- R2: The main register sits at byte offset CTL_ADDR (0x9D). Its bits are: bit 6 open, bit 5 close, bit 4 lock, bit 3 global enable, bits 2:0 base segment. The extended register sits at EXT_ADDR (0x9E). Its bits are: bit 7 high enable, bits 2:1 top-segment size, bit 0 top-segment enable. A write with cfg_wr=1 stores (old AND NOT mask) OR (data AND mask) into the addressed register.
- R3: A write to any other offset changes neither register. A read of any other offset returns 0.
- R4: The lock is evaluated after the write is merged. A write that sets the lock bit stores open=0 in the same update, even when its data has bit 6 set.
- R5: While locked, writes to the main register leave bits 6, 4, 3 and 2:0 unchanged. Bit 5 (close) stays writable.
- R6: While locked, writes to the extended register leave bits 7, 2:1 and 0 unchanged. Bits 6:3 stay writable.
- R7: Once set, the lock stays set until reset. After reset, all bits are writable again.
- R8: cfg_rdata returns the stored value of the register at cfg_addr in the same cycle. The open bit reads 0 whenever the lock is set.
- R9: The decoded outputs come from a register stage. After the edge that updates a stored register, they take the new values at the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_addr | input | ADDR_W | Byte offset for both read and write |
| cfg_wr | input | 1 | Write strobe |
| cfg_wdata | input | 8 | Write data |
| cfg_rdata | output | 8 | Read data for cfg_addr |
| smr_open | output | 1 | Decoded open bit |
| smr_global_en | output | 1 | Decoded global enable |
| smr_base_seg | output | 3 | Decoded base segment |
| smr_high_en | output | 1 | Decoded high enable |
| smr_topseg_size | output | 2 | Decoded top-segment size |
| smr_topseg_en | output | 1 | Decoded top-segment enable |

## Verification
The bench goes after a single write that sets the lock with open=1 in the same data byte. A design that applies the lock before merging the write would leave open=1 stored. It also writes all-ones and all-zeros patterns to both registers once they are locked. This shows whether a frozen field still moves, or whether a field that should stay free (close, bits 6:3 of the extended register) has been frozen by mistake. Resets between rounds check that the lock and the masks return to their reset values, so a lock that never releases is caught. Writes to offsets next to the two registers, and the one-edge lag of the decoded outputs, are compared against a bench model on every update.

// File: rtl/smram_lock_pkg.sv
package smram_lock_pkg;
    localparam int DATA_W    = 8;
    localparam int OPEN_BIT  = 6;
    localparam int CLOSE_BIT = 5;
    localparam int LOCK_BIT  = 4;
    localparam int GEN_BIT   = 3;
    localparam int SEG_LSB   = 0;
    localparam int SEG_W     = 3;
    localparam int HIGH_BIT  = 7;
    localparam int TSZ_LSB   = 1;
    localparam int TSZ_W     = 2;
    localparam int TEN_BIT   = 0;

    // bits that lose write permission once locked
    localparam logic [DATA_W-1:0] CTL_FROZEN = 8'h5F;
    localparam logic [DATA_W-1:0] EXT_FROZEN = 8'h87;

    typedef struct packed {
        logic [DATA_W-1:0] ctl;
        logic [DATA_W-1:0] ext;
        logic [DATA_W-1:0] ctl_wmask;
        logic [DATA_W-1:0] ext_wmask;
    } smram_state_t;

    typedef struct packed {
        logic             open;
        logic             global_en;
        logic [SEG_W-1:0] base_seg;
        logic             high_en;
        logic [TSZ_W-1:0] topseg_size;
        logic             topseg_en;
    } smram_fields_t;

    function automatic smram_fields_t decode_fields(logic [DATA_W-1:0] ctl,
                                                     logic [DATA_W-1:0] ext);
        smram_fields_t f;
        f.open        = ctl[OPEN_BIT];
        f.global_en   = ctl[GEN_BIT];
        f.base_seg    = ctl[SEG_LSB +: SEG_W];
        f.high_en     = ext[HIGH_BIT];
        f.topseg_size = ext[TSZ_LSB +: TSZ_W];
        f.topseg_en   = ext[TEN_BIT];
        return f;
    endfunction
endpackage

// File: rtl/smram_mask_merge.sv
module smram_mask_merge #(
    parameter int W = 8
) (
    input  logic         sel,
    input  logic [W-1:0] old_val,
    input  logic [W-1:0] new_val,
    input  logic [W-1:0] wmask,
    output logic [W-1:0] merged
);
    always_comb begin
        merged = old_val;
        if (sel) begin
            merged = (old_val & ~wmask) | (new_val & wmask);
        end
    end
endmodule

// File: rtl/smram_lock_ctrl.sv
module smram_lock_ctrl
    import smram_lock_pkg::*;
(
    input  logic [DATA_W-1:0] ctl_in,
    input  logic [DATA_W-1:0] ext_in,
    input  logic [DATA_W-1:0] ctl_wmask_in,
    input  logic [DATA_W-1:0] ext_wmask_in,
    output logic [DATA_W-1:0] ctl_out,
    output logic [DATA_W-1:0] ext_out,
    output logic [DATA_W-1:0] ctl_wmask_out,
    output logic [DATA_W-1:0] ext_wmask_out
);
    logic locked;

    always_comb begin
        locked        = ctl_in[LOCK_BIT];
        ctl_out       = ctl_in;
        ext_out       = ext_in;
        ctl_wmask_out = ctl_wmask_in;
        ext_wmask_out = ext_wmask_in;
        if (locked) begin
            ctl_out[OPEN_BIT] = 1'b0;
            ctl_wmask_out     = ctl_wmask_in & ~CTL_FROZEN;
            ext_wmask_out     = ext_wmask_in & ~EXT_FROZEN;
        end
    end
endmodule

// File: rtl/smram_field_decode.sv
module smram_field_decode
    import smram_lock_pkg::*;
#(
    parameter logic [DATA_W-1:0] CTL_DEFAULT = 8'h02,
    parameter logic [DATA_W-1:0] EXT_DEFAULT = 8'h00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] ctl,
    input  logic [DATA_W-1:0] ext,
    output smram_fields_t     fields_q
);
    smram_fields_t fields_d;

    always_comb begin
        fields_d = decode_fields(ctl, ext);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fields_q <= decode_fields(CTL_DEFAULT, EXT_DEFAULT);
        end else begin
            fields_q <= fields_d;
        end
    end

    // R9
    open_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> fields_q.open == $past(ctl[OPEN_BIT]));

    // R9
    topseg_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> fields_q.topseg_size == $past(ext[TSZ_LSB +: TSZ_W]));
endmodule

// File: rtl/smram_lock_regs.sv
module smram_lock_regs
    import smram_lock_pkg::*;
#(
    parameter int                ADDR_W      = 8,
    parameter logic [ADDR_W-1:0] CTL_ADDR    = 8'h9D,
    parameter logic [ADDR_W-1:0] EXT_ADDR    = 8'h9E,
    parameter logic [DATA_W-1:0] CTL_DEFAULT = 8'h02,
    parameter logic [DATA_W-1:0] EXT_DEFAULT = 8'h00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic              cfg_wr,
    input  logic [7:0]        cfg_wdata,
    output logic [7:0]        cfg_rdata,
    output logic              smr_open,
    output logic              smr_global_en,
    output logic [2:0]        smr_base_seg,
    output logic              smr_high_en,
    output logic [1:0]        smr_topseg_size,
    output logic              smr_topseg_en
);
    localparam logic [DATA_W-1:0] ALL_ONES = {DATA_W{1'b1}};

    smram_state_t      state_d, state_q;
    smram_fields_t     fields_q;
    logic              wr_ctl, wr_ext;
    logic [DATA_W-1:0] ctl_merged, ext_merged;
    logic [DATA_W-1:0] ctl_locked, ext_locked, ctl_wmask_nx, ext_wmask_nx;

    assign wr_ctl = cfg_wr && (cfg_addr == CTL_ADDR);
    assign wr_ext = cfg_wr && (cfg_addr == EXT_ADDR);

    smram_mask_merge #(.W(DATA_W)) i_merge_ctl (
        .sel(wr_ctl), .old_val(state_q.ctl), .new_val(cfg_wdata),
        .wmask(state_q.ctl_wmask), .merged(ctl_merged)
    );

    smram_mask_merge #(.W(DATA_W)) i_merge_ext (
        .sel(wr_ext), .old_val(state_q.ext), .new_val(cfg_wdata),
        .wmask(state_q.ext_wmask), .merged(ext_merged)
    );

    smram_lock_ctrl i_lock (
        .ctl_in(ctl_merged), .ext_in(ext_merged),
        .ctl_wmask_in(state_q.ctl_wmask), .ext_wmask_in(state_q.ext_wmask),
        .ctl_out(ctl_locked), .ext_out(ext_locked),
        .ctl_wmask_out(ctl_wmask_nx), .ext_wmask_out(ext_wmask_nx)
    );

    always_comb begin
        state_d.ctl       = ctl_locked;
        state_d.ext       = ext_locked;
        state_d.ctl_wmask = ctl_wmask_nx;
        state_d.ext_wmask = ext_wmask_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q.ctl       <= CTL_DEFAULT;
            state_q.ext       <= EXT_DEFAULT;
            state_q.ctl_wmask <= ALL_ONES;
            state_q.ext_wmask <= ALL_ONES;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        cfg_rdata = '0;
        if (cfg_addr == CTL_ADDR) begin
            cfg_rdata = state_q.ctl;
        end else if (cfg_addr == EXT_ADDR) begin
            cfg_rdata = state_q.ext;
        end
    end

    smram_field_decode #(.CTL_DEFAULT(CTL_DEFAULT), .EXT_DEFAULT(EXT_DEFAULT)) i_decode (
        .clk(clk), .rst_n(rst_n), .ctl(state_q.ctl), .ext(state_q.ext),
        .fields_q(fields_q)
    );

    assign smr_open        = fields_q.open;
    assign smr_global_en   = fields_q.global_en;
    assign smr_base_seg    = fields_q.base_seg;
    assign smr_high_en     = fields_q.high_en;
    assign smr_topseg_size = fields_q.topseg_size;
    assign smr_topseg_en   = fields_q.topseg_en;

    // R4
    lock_forces_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state_q.ctl[LOCK_BIT] |-> !state_q.ctl[OPEN_BIT]);

    // R7
    lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state_q.ctl[LOCK_BIT] |=> state_q.ctl[LOCK_BIT]);

    // R5
    ctl_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state_q.ctl[LOCK_BIT] |=> $stable(state_q.ctl & CTL_FROZEN));

    // R6
    ext_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state_q.ctl[LOCK_BIT] |=> $stable(state_q.ext & EXT_FROZEN));

    // R3
    stray_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && cfg_addr != CTL_ADDR && cfg_addr != EXT_ADDR)
            |=> ($stable(state_q.ctl) && $stable(state_q.ext)));

    // R1
    unlocked_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !state_q.ctl[LOCK_BIT] |-> (state_q.ctl_wmask == ALL_ONES && state_q.ext_wmask == ALL_ONES));
endmodule

// File: tb/test_smram_lock_regs.sv
module test_smram_lock_regs;
    localparam int         CLK_PERIOD = 10;
    localparam logic [7:0] CTL_A = 8'h9D;
    localparam logic [7:0] EXT_A = 8'h9E;
    localparam logic [7:0] CTL_RST = 8'h02;
    localparam logic [7:0] EXT_RST = 8'h00;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] cfg_addr = '0;
    logic       cfg_wr = 1'b0;
    logic [7:0] cfg_wdata = '0;
    logic [7:0] cfg_rdata;
    logic       smr_open, smr_global_en, smr_high_en, smr_topseg_en;
    logic [2:0] smr_base_seg;
    logic [1:0] smr_topseg_size;

    int checks = 0;
    int fails  = 0;

    // bench model
    logic [7:0] m_ctl, m_ext, m_cmask, m_emask;

    always #(CLK_PERIOD/2) clk = ~clk;

    smram_lock_regs i_smram_lock_regs (
        .clk(clk), .rst_n(rst_n), .cfg_addr(cfg_addr), .cfg_wr(cfg_wr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .smr_open(smr_open),
        .smr_global_en(smr_global_en), .smr_base_seg(smr_base_seg),
        .smr_high_en(smr_high_en), .smr_topseg_size(smr_topseg_size),
        .smr_topseg_en(smr_topseg_en)
    );

    function automatic logic [8:0] exp_fields(logic [7:0] c, logic [7:0] e);
        return {c[6], c[3], c[2:0], e[7], e[2:1], e[0]};
    endfunction

    task automatic check(string req, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic model_write(logic [7:0] a, logic [7:0] d);
        if (a == CTL_A) m_ctl = (m_ctl & ~m_cmask) | (d & m_cmask);
        else if (a == EXT_A) m_ext = (m_ext & ~m_emask) | (d & m_emask);
        if (m_ctl[4]) begin
            m_ctl[6] = 1'b0;
            m_cmask  = m_cmask & ~8'h5F;
            m_emask  = m_emask & ~8'h87;
        end
    endtask

    task automatic read_chk(string req, logic [7:0] a, logic [7:0] exp);
        cfg_addr = a;
        #1;
        check(req, {8'h0, cfg_rdata}, {8'h0, exp});
    endtask

    task automatic check_all(string req);
        read_chk(req, CTL_A, m_ctl);
        read_chk(req, EXT_A, m_ext);
        check({req, "/R9"},
              {7'h0, smr_open, smr_global_en, smr_base_seg, smr_high_en, smr_topseg_size, smr_topseg_en},
              {7'h0, exp_fields(m_ctl, m_ext)});
    endtask

    task automatic do_write(string req, logic [7:0] a, logic [7:0] d);
        @(negedge clk);
        cfg_addr = a; cfg_wdata = d; cfg_wr = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0;
        model_write(a, d);
        @(negedge clk);
        check_all(req);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; cfg_wr = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        m_ctl = CTL_RST; m_ext = EXT_RST; m_cmask = 8'hFF; m_emask = 8'hFF;
        @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED1234));
        do_reset();
        check_all("R1_reset");

        // R2: full writes before lock
        do_write("R2_ctl_all", CTL_A, 8'hEF);
        do_write("R2_ext_all", EXT_A, 8'hFF);
        do_write("R2_ext_zero", EXT_A, 8'h00);
        // R3: stray offsets
        do_write("R3_stray", 8'h9C, 8'hFF);
        do_write("R3_stray", 8'h9F, 8'h10);
        read_chk("R3_read_other", 8'h9F, 8'h00);
        // R4: lock and open in same write
        do_write("R4_lock_open", CTL_A, 8'h5A);
        check("R8_open_reads0", {15'h0, m_ctl[6]}, 16'h0);
        // R5 / R6: frozen vs free bits
        do_write("R5_ctl_ones", CTL_A, 8'hFF);
        do_write("R5_ctl_zero", CTL_A, 8'h00);
        do_write("R6_ext_ones", EXT_A, 8'hFF);
        do_write("R6_ext_zero", EXT_A, 8'h00);
        read_chk("R5_close_free", CTL_A, {m_ctl[7:6], 1'b0, m_ctl[4:0]});
        // R7: reset releases lock
        do_reset();
        check_all("R7_after_reset");
        do_write("R7_writable", CTL_A, 8'h4B);
        do_write("R7_writable", EXT_A, 8'h86);

        // random rounds
        for (int r = 0; r < 6; r++) begin
            do_reset();
            check_all("R1_round");
            for (int k = 0; k < 40; k++) begin
                logic [7:0] a, d;
                int sel = $urandom % 5;
                a = (sel < 2) ? CTL_A : (sel < 4) ? EXT_A : 8'($urandom);
                d = 8'($urandom);
                if (a == CTL_A && ($urandom % 6) != 0) d[4] = 1'b0;
                do_write("R2_R4_R5_R6_rand", a, d);
            end
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule